// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, lane by lane. It can pass data across in either direction. Each direction has a storage register with its own capture clock. A stored word can therefore be sent out later in place of the live value. The tri-state bus pins are split into three signals for each bus: an input vector, an output vector and an output-enable vector with one bit per lane. The pad ring or a wrapper combines them.

Each lane carries `WIDTH` bits and has a full control set of its own:
- an active-low output enable;
- a direction select;
- a capture clock for the A-side register and a capture clock for the B-side register;
- two selects, each of which chooses between the live word and the stored word for one direction.

Capture never depends on the enable or direction inputs. One register can be loaded while the buses are isolated, or while the other register's contents are being driven out. With the default of two 8-bit lanes, the block serves as two separate byte paths or as one 16-bit path.

Top module: `reg_bus_xcvr`

## Requirements
- R1: A rising edge on a lane's `cap_a_clk` stores that lane's `a_in` into its A-side register. This holds for any value of `out_en_n` and `drive_b`.
- R2: A rising edge on a lane's `cap_b_clk` stores that lane's `b_in` into its B-side register. This holds for any value of `out_en_n` and `drive_b`.
- R3: While `out_en_n` of a lane is 1, both `a_oe` and `b_oe` of that lane are 0, and that lane's `a_out` and `b_out` are all zeros.
- R4: With `out_en_n` at 0, `drive_b` at 0 sets `a_oe`=1 and `b_oe`=0, and `drive_b` at 1 sets `b_oe`=1 and `a_oe`=0. The two enables of a lane are never 1 together.
- R5: While the A bus is driven, `use_b_store`=0 makes `a_out` equal the live `b_in`, and `use_b_store`=1 makes it equal the B-side register.
- R6: While the B bus is driven, `use_a_store`=0 makes `b_out` equal the live `a_in`, and `use_a_store`=1 makes it equal the A-side register.
- R7: `rst_n`=0 clears both registers of every lane to zero at once, without waiting for a clock.
- R8: When both capture clocks of a lane rise together, both registers update, each from its own bus.
- R9: Lane k occupies bits [k*WIDTH +: WIDTH] of each data vector and bit k of each control vector. Stimulus on one lane leaves the outputs and registers of every other lane unchanged.
- R10: A driven output always equals exactly one of its two sources, the live word or the stored word, with no mix of bits from both. This also holds right after its select changes.
- R11: A capture into one register while the other register's word is being driven leaves the driven output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of all capture registers |
| out_en_n | input | LANES | Active-low output enable, one bit per lane |
| drive_b | input | LANES | Direction select: 1 drives bus B, 0 drives bus A |
| cap_a_clk | input | LANES | Capture clock of the A-side register, rising edge |
| cap_b_clk | input | LANES | Capture clock of the B-side register, rising edge |
| use_a_store | input | LANES | 1 sends the stored A word to bus B; 0 sends the live A word |
| use_b_store | input | LANES | 1 sends the stored B word to bus A; 0 sends the live B word |
| a_in | input | LANES*WIDTH | Value seen on the A bus pins |
| b_in | input | LANES*WIDTH | Value seen on the B bus pins |
| a_out | output | LANES*WIDTH | Value driven onto the A bus pins |
| b_out | output | LANES*WIDTH | Value driven onto the B bus pins |
| a_oe | output | LANES | Output enable of each lane's A bus pins |
| b_oe | output | LANES | Output enable of each lane's B bus pins |

## Verification
Enables, selects and live data reach the outputs with no register between them. The bench therefore reads those results 1 ns after it drives the inputs, within the same clock period.

A captured word is visible only after the rising edge of its capture clock. Each capture pulse is raised on one falling edge of the bench clock and lowered on the next. The stored word is read 1 ns after the pulse ends, so the value at the outputs never depends on the order of events at the capture edge.

Reset is checked while `rst_n` is still low, before any capture clock has risen.

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int LANES = 2,
  parameter int WIDTH = 8
) (
  input  logic                   rst_n,
  input  logic [LANES-1:0]       out_en_n,
  input  logic [LANES-1:0]       drive_b,
  input  logic [LANES-1:0]       cap_a_clk,
  input  logic [LANES-1:0]       cap_b_clk,
  input  logic [LANES-1:0]       use_a_store,
  input  logic [LANES-1:0]       use_b_store,
  input  logic [LANES*WIDTH-1:0] a_in,
  input  logic [LANES*WIDTH-1:0] b_in,
  output logic [LANES*WIDTH-1:0] a_out,
  output logic [LANES*WIDTH-1:0] b_out,
  output logic [LANES-1:0]       a_oe,
  output logic [LANES-1:0]       b_oe
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LO = g * WIDTH;
    logic [WIDTH-1:0] a_store, b_store;

    always_ff @(posedge cap_a_clk[g] or negedge rst_n)
      if (!rst_n) a_store <= '0;
      else        a_store <= a_in[LO +: WIDTH];

    always_ff @(posedge cap_b_clk[g] or negedge rst_n)
      if (!rst_n) b_store <= '0;
      else        b_store <= b_in[LO +: WIDTH];

    assign a_oe[g] = !out_en_n[g] && !drive_b[g];
    assign b_oe[g] = !out_en_n[g] &&  drive_b[g];

    assign a_out[LO +: WIDTH] = !a_oe[g] ? '0 :
                                use_b_store[g] ? b_store : b_in[LO +: WIDTH];
    assign b_out[LO +: WIDTH] = !b_oe[g] ? '0 :
                                use_a_store[g] ? a_store : a_in[LO +: WIDTH];
  end
endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int LANES = 2,
  parameter int WIDTH = 8
) (
  input logic                   rst_n,
  input logic [LANES-1:0]       out_en_n,
  input logic [LANES-1:0]       drive_b,
  input logic [LANES-1:0]       cap_a_clk,
  input logic [LANES-1:0]       cap_b_clk,
  input logic [LANES-1:0]       use_a_store,
  input logic [LANES-1:0]       use_b_store,
  input logic [LANES*WIDTH-1:0] a_in,
  input logic [LANES*WIDTH-1:0] b_in,
  input logic [LANES*WIDTH-1:0] a_out,
  input logic [LANES*WIDTH-1:0] b_out,
  input logic [LANES-1:0]       a_oe,
  input logic [LANES-1:0]       b_oe
);
  for (genvar g = 0; g < LANES; g++) begin : g_chk
    localparam int LO = g * WIDTH;
    logic [WIDTH-1:0] sh_a, sh_b;

    always_ff @(posedge cap_a_clk[g] or negedge rst_n)
      if (!rst_n) sh_a <= '0;
      else        sh_a <= a_in[LO +: WIDTH];

    always_ff @(posedge cap_b_clk[g] or negedge rst_n)
      if (!rst_n) sh_b <= '0;
      else        sh_b <= b_in[LO +: WIDTH];

    p_iso_r3: assert property (@(posedge cap_a_clk[g]) disable iff (!rst_n)
      out_en_n[g] |-> (!a_oe[g] && !b_oe[g] && a_out[LO +: WIDTH] == '0 && b_out[LO +: WIDTH] == '0));
    p_excl_r4: assert property (@(posedge cap_b_clk[g]) disable iff (!rst_n)
      !(a_oe[g] && b_oe[g]));
    p_dir_r4: assert property (@(posedge cap_b_clk[g]) disable iff (!rst_n)
      !out_en_n[g] |-> (b_oe[g] == drive_b[g] && a_oe[g] == !drive_b[g]));
    p_stored_a_r6: assert property (@(posedge cap_a_clk[g]) disable iff (!rst_n)
      (b_oe[g] && use_a_store[g]) |-> b_out[LO +: WIDTH] == sh_a);
    p_live_b_r5: assert property (@(posedge cap_b_clk[g]) disable iff (!rst_n)
      (a_oe[g] && !use_b_store[g]) |-> a_out[LO +: WIDTH] == b_in[LO +: WIDTH]);
    p_stored_b_r5: assert property (@(posedge cap_b_clk[g]) disable iff (!rst_n)
      (a_oe[g] && use_b_store[g]) |-> a_out[LO +: WIDTH] == sh_b);
    p_one_src_r10: assert property (@(posedge cap_a_clk[g]) disable iff (!rst_n)
      b_oe[g] |-> (b_out[LO +: WIDTH] == a_in[LO +: WIDTH] || b_out[LO +: WIDTH] == sh_a));
  end
endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
  .rst_n(rst_n), .out_en_n(out_en_n), .drive_b(drive_b),
  .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk),
  .use_a_store(use_a_store), .use_b_store(use_b_store),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
  .a_oe(a_oe), .b_oe(b_oe)
);

// File: tb/test_reg_bus_xcvr.sv
module test_reg_bus_xcvr;
  localparam int LANES = 2;
  localparam int W = 8;

  logic clk = 0;
  logic rst_n;
  logic [LANES-1:0] out_en_n, drive_b, cap_a_clk, cap_b_clk, use_a_store, use_b_store;
  logic [LANES*W-1:0] a_in, b_in, a_out, b_out;
  logic [LANES-1:0] a_oe, b_oe;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  reg_bus_xcvr #(.LANES(LANES), .WIDTH(W)) i_reg_bus_xcvr (
    .rst_n(rst_n), .out_en_n(out_en_n), .drive_b(drive_b),
    .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk),
    .use_a_store(use_a_store), .use_b_store(use_b_store),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
    .a_oe(a_oe), .b_oe(b_oe));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl(int l, bit en_n, bit dirb, bit ua, bit ub);
    out_en_n[l] = en_n; drive_b[l] = dirb; use_a_store[l] = ua; use_b_store[l] = ub;
    #1;
  endtask

  task automatic pulse(int l, bit do_a, bit do_b);
    @(negedge clk);
    if (do_a) cap_a_clk[l] = 1'b1;
    if (do_b) cap_b_clk[l] = 1'b1;
    @(negedge clk);
    cap_a_clk[l] = 1'b0; cap_b_clk[l] = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 0; #1;
    ctl(0, 0, 1, 1, 1);
    chk("R7 A-side store after reset", b_out[0 +: W], 8'h00);
    ctl(0, 0, 0, 1, 1);
    chk("R7 B-side store after reset", a_out[0 +: W], 8'h00);
    @(negedge clk); rst_n = 1; #1;
  endtask

  task automatic t_iso;
    ctl(0, 1, 1, 1, 1);
    a_in[0 +: W] = 8'h5A; b_in[0 +: W] = 8'hC3; #1;
    chk("R3 oe pair isolated", {30'd0, a_oe[0], b_oe[0]}, 32'd0);
    chk("R3 outputs zero isolated", {a_out[0 +: W], b_out[0 +: W]}, 16'h0000);
    pulse(0, 1, 0);
    chk("R3 isolated after capture", {a_out[0 +: W], b_out[0 +: W]}, 16'h0000);
    ctl(0, 0, 1, 1, 1);
    chk("R1 capture while isolated", b_out[0 +: W], 8'h5A);
  endtask

  task automatic t_dir;
    ctl(0, 0, 0, 0, 0);
    chk("R4 dir low", {30'd0, a_oe[0], b_oe[0]}, 32'd2);
    chk("R4 B out idle", b_out[0 +: W], 8'h00);
    ctl(0, 0, 1, 0, 0);
    chk("R4 dir high", {30'd0, a_oe[0], b_oe[0]}, 32'd1);
    chk("R4 A out idle", a_out[0 +: W], 8'h00);
  endtask

  task automatic t_live;
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    for (int k = 0; k < 4; k++) begin
      ctl(0, 0, 1, 0, 0);
      a_in[0 +: W] = pats[k]; #1;
      chk("R6 live A to B", b_out[0 +: W], {24'd0, pats[k]});
      ctl(0, 0, 0, 0, 0);
      b_in[0 +: W] = ~pats[k]; #1;
      chk("R5 live B to A", a_out[0 +: W], {24'd0, ~pats[k]});
    end
  endtask

  task automatic t_stored;
    b_in[0 +: W] = 8'h96;
    pulse(0, 0, 1);
    ctl(0, 0, 0, 0, 1);
    b_in[0 +: W] = 8'h11; #1;
    chk("R2 stored B to A", a_out[0 +: W], 8'h96);
    chk("R5 stored ignores live", a_out[0 +: W], 8'h96);
  endtask

  task automatic t_while_drive;
    ctl(0, 0, 0, 0, 1);
    b_in[0 +: W] = 8'h42;
    pulse(0, 0, 1);
    a_in[0 +: W] = 8'hE7;
    pulse(0, 1, 0);
    chk("R11 A-capture keeps A out", a_out[0 +: W], 8'h42);
    ctl(0, 0, 1, 1, 0);
    b_in[0 +: W] = 8'h7E;
    pulse(0, 0, 1);
    chk("R11 B-capture keeps B out", b_out[0 +: W], 8'hE7);
    ctl(0, 0, 0, 0, 1);
    chk("R11 later B capture seen", a_out[0 +: W], 8'h7E);
  endtask

  task automatic t_simul;
    a_in[0 +: W] = 8'h81; b_in[0 +: W] = 8'h18;
    pulse(0, 1, 1);
    a_in[0 +: W] = 8'h00; b_in[0 +: W] = 8'h00;
    ctl(0, 0, 1, 1, 1);
    chk("R8 both A", b_out[0 +: W], 8'h81);
    ctl(0, 0, 0, 1, 1);
    chk("R8 both B", a_out[0 +: W], 8'h18);
  endtask

  task automatic t_switch;
    a_in[0 +: W] = 8'h0F;
    pulse(0, 1, 0);
    a_in[0 +: W] = 8'hF0;
    ctl(0, 0, 1, 0, 0);
    for (int k = 0; k < 4; k++) begin
      use_a_store[0] = k[0]; #1;
      chk("R10 one source", b_out[0 +: W], k[0] ? 8'h0F : 8'hF0);
    end
  endtask

  task automatic t_lanes;
    logic [W-1:0] keep;
    ctl(0, 0, 1, 1, 0);
    keep = b_out[0 +: W];
    ctl(1, 0, 1, 1, 0);
    a_in[W +: W] = 8'hBE; a_in[0 +: W] = 8'h00;
    pulse(1, 1, 0);
    chk("R9 lane1 captured", b_out[W +: W], 8'hBE);
    chk("R9 lane0 store untouched", b_out[0 +: W], {24'd0, keep});
    ctl(1, 1, 0, 0, 0);
    chk("R9 lane0 oe unaffected", {30'd0, a_oe[0], b_oe[0]}, 32'd1);
    chk("R9 lane1 isolated", {30'd0, a_oe[1], b_oe[1]}, 32'd0);
  endtask

  initial begin
    rst_n = 0; out_en_n = '1; drive_b = '0; cap_a_clk = '0; cap_b_clk = '0;
    use_a_store = '0; use_b_store = '0; a_in = '0; b_in = '0;
    @(negedge clk);
    t_reset;
    t_iso;
    t_dir;
    t_live;
    t_stored;
    t_while_drive;
    t_simul;
    t_switch;
    t_lanes;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule